// File: doc/BRIEF.md
# Linked-Pair Reservation Monitor

This block sits in front of a word-addressed data memory and lets a core build atomic read-modify-write sequences from two requests: a linked load and a conditional store. A linked load returns the addressed word like an ordinary load and opens a single reservation on that word address. A later conditional store to the same word commits only if nothing has written that word in between. It returns a success flag, so software can retry the whole sequence when the flag comes back as 0.

Writes by other agents are reported on a snoop input as a word address. An ordinary store from the core that lands on the reserved word also breaks the reservation. Each request on the core port completes in exactly one cycle. Request addresses are byte addresses that must be word aligned. A misaligned request is flagged in the response and has no other effect.

Top module: `atomic_resv_mon`

## Requirements
- R1: A linked load (req_op = 2) at an aligned address returns the stored word on rsp_rdata in the response cycle and opens a reservation on that word address.
- R2: A conditional store (req_op = 3) whose address matches an intact reservation writes req_wdata to memory and returns rsp_sc_ok = 1.
- R3: A snoop write to the reserved word address, seen between the linked load and the conditional store, makes the conditional store fail: rsp_sc_ok = 0 and memory unchanged.
- R4: An ordinary core store (req_op = 1) to the reserved word breaks the reservation, so the next conditional store to that word fails and does not write.
- R5: Every aligned conditional store clears the reservation, whether it succeeds or fails. A second conditional store after a successful one fails.
- R6: A conditional store to a word other than the reserved one fails and leaves that word unchanged.
- R7: A snoop write to the reserved word in the same cycle as a conditional store to that word makes the store fail.
- R8: A snoop write to a different word address leaves the reservation intact.
- R9: A request whose address has bits [1:0] not zero returns rsp_misaligned = 1 and rsp_sc_ok = 0. It writes nothing and leaves the reservation as it was.
- R10: Reset clears the reservation, so a conditional store after reset fails.
- R11: rsp_valid is high in the cycle after an accepted request and low otherwise. An ordinary load (req_op = 0) returns the stored word.
- R12: A snoop write to the same word in the same cycle as a linked load leaves no reservation open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr | input | 32 | Byte address, must be word aligned |
| req_wdata | input | 32 | Store data |
| snoop_valid | input | 1 | Another agent wrote memory this cycle |
| snoop_waddr | input | 30 | Word address of that foreign write |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read word for a load or linked load, zero otherwise |
| rsp_sc_ok | output | 1 | Conditional store committed |
| rsp_misaligned | output | 1 | Previous request had an unaligned address |

## Verification
Two events can land in the same cycle: a foreign write reported on the snoop input and a core request aimed at the reserved word. The bench drives a snoop and a conditional store to the same word in one cycle, and separately a snoop and a linked load to the same word in one cycle. In both cases the conditional store that follows must report failure. A follow-up load must show that memory kept its earlier value.

// File: rtl/atomic_resv_pkg.sv
package atomic_resv_pkg;
  typedef enum logic [1:0] {
    OPC_LOAD  = 2'd0,
    OPC_STORE = 2'd1,
    OPC_LINK  = 2'd2,
    OPC_COND  = 2'd3
  } opc_e;
endpackage

// File: rtl/resv_decode.sv
module resv_decode #(
  parameter int ADDR_W = 32,
  localparam int WADDR_W = ADDR_W - 2
) (
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               load_go,
  output logic               store_go,
  output logic               link_go,
  output logic               cond_go,
  output logic               misaligned,
  output logic [WADDR_W-1:0] word_addr
);
  import atomic_resv_pkg::*;

  logic  aligned;
  opc_e  opc;

  always_comb begin
    opc        = opc_e'(req_op);
    aligned    = (req_addr[1:0] == 2'b00);
    misaligned = req_valid && !aligned;
    word_addr  = req_addr[ADDR_W-1:2];
    load_go    = req_valid && aligned && (opc == OPC_LOAD);
    store_go   = req_valid && aligned && (opc == OPC_STORE);
    link_go    = req_valid && aligned && (opc == OPC_LINK);
    cond_go    = req_valid && aligned && (opc == OPC_COND);
  end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int WADDR_W = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_go,
  input  logic               cond_go,
  input  logic               store_go,
  input  logic [WADDR_W-1:0] req_waddr,
  input  logic               snoop_valid,
  input  logic [WADDR_W-1:0] snoop_waddr,
  output logic               cond_pass,
  output logic               resv_valid
);
  logic [WADDR_W-1:0] resv_addr;
  logic               snoop_hits_resv;
  logic               snoop_hits_req;
  logic               store_hits_resv;

  always_comb begin
    snoop_hits_resv = snoop_valid && (snoop_waddr == resv_addr);
    snoop_hits_req  = snoop_valid && (snoop_waddr == req_waddr);
    store_hits_resv = store_go && (req_waddr == resv_addr);
    cond_pass = cond_go && resv_valid && (resv_addr == req_waddr) && !snoop_hits_resv;
  end

  // A fresh linked load replaces any older reservation; every other event only clears.
  always_ff @(posedge clk) begin
    if (rst) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else if (link_go) begin
      resv_valid <= !snoop_hits_req;
      resv_addr  <= req_waddr;
    end else if (cond_go || snoop_hits_resv || store_hits_resv) begin
      resv_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_mem.sv
module resv_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store_arr [DEPTH];

  // Single port, read-first, registered output: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) store_arr[idx] <= wdata;
    rdata <= store_arr[idx];
  end
endmodule

// File: rtl/atomic_resv_mon.sv
module atomic_resv_mon #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int WADDR_W = ADDR_W - 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               snoop_valid,
  input  logic [WADDR_W-1:0] snoop_waddr,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_sc_ok,
  output logic               rsp_misaligned
);
  logic               load_go, store_go, link_go, cond_go, misaligned;
  logic [WADDR_W-1:0] word_addr;
  logic               cond_pass;
  logic               resv_valid_q;
  logic [DATA_W-1:0]  mem_rdata;
  logic               read_q;

  resv_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .load_go    (load_go),
    .store_go   (store_go),
    .link_go    (link_go),
    .cond_go    (cond_go),
    .misaligned (misaligned),
    .word_addr  (word_addr)
  );

  resv_tracker #(.WADDR_W(WADDR_W)) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .link_go     (link_go),
    .cond_go     (cond_go),
    .store_go    (store_go),
    .req_waddr   (word_addr),
    .snoop_valid (snoop_valid),
    .snoop_waddr (snoop_waddr),
    .cond_pass   (cond_pass),
    .resv_valid  (resv_valid_q)
  );

  resv_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (store_go || cond_pass),
    .idx   (word_addr[IDX_W-1:0]),
    .wdata (req_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_sc_ok      <= 1'b0;
      rsp_misaligned <= 1'b0;
      read_q         <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_sc_ok      <= cond_pass;
      rsp_misaligned <= misaligned;
      read_q         <= load_go || link_go;
    end
  end

  assign rsp_rdata = read_q ? mem_rdata : '0;
endmodule

// File: rtl/atomic_resv_chk.sv
module atomic_resv_chk #(
  parameter int ADDR_W = 32,
  localparam int WADDR_W = ADDR_W - 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         req_op,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               snoop_valid,
  input logic [WADDR_W-1:0] snoop_waddr,
  input logic               rsp_valid,
  input logic               rsp_sc_ok,
  input logic               rsp_misaligned,
  input logic               resv_valid
);
  logic cond_req;
  assign cond_req = req_valid && (req_op == 2'd3) && (req_addr[1:0] == 2'b00);

  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r9_misaligned_never_ok: assert property (@(posedge clk) disable iff (rst)
    rsp_misaligned |-> !rsp_sc_ok);

  a_r7_snoop_kills_cond: assert property (@(posedge clk) disable iff (rst)
    (cond_req && snoop_valid && (snoop_waddr == req_addr[ADDR_W-1:2])) |=> !rsp_sc_ok);

  a_r5_cond_clears_resv: assert property (@(posedge clk) disable iff (rst)
    cond_req |=> !resv_valid);

  a_r2_ok_needs_resv: assert property (@(posedge clk) disable iff (rst)
    rsp_sc_ok |-> $past(resv_valid));

  a_r10_reset_clears_resv: assert property (@(posedge clk)
    rst |=> !resv_valid);
endmodule

bind atomic_resv_mon atomic_resv_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_op         (req_op),
  .req_addr       (req_addr),
  .snoop_valid    (snoop_valid),
  .snoop_waddr    (snoop_waddr),
  .rsp_valid      (rsp_valid),
  .rsp_sc_ok      (rsp_sc_ok),
  .rsp_misaligned (rsp_misaligned),
  .resv_valid     (resv_valid_q)
);

// File: tb/atomic_resv_mon_tb.sv
module atomic_resv_mon_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        snoop_valid = 1'b0;
  logic [29:0] snoop_waddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_sc_ok;
  logic        rsp_misaligned;

  int checks = 0;
  int fails  = 0;

  logic        r_valid, r_ok, r_mis;
  logic [31:0] r_data;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;
  localparam logic [31:0] A = 32'h40, B = 32'h80, C = 32'h44;

  always #2 clk = ~clk;

  atomic_resv_mon u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_waddr(snoop_waddr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_sc_ok(rsp_sc_ok), .rsp_misaligned(rsp_misaligned)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xact(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                      input logic sv, input logic [31:0] saddr);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    snoop_valid = sv; snoop_waddr = saddr[31:2];
    @(posedge clk); #1;
    r_valid = rsp_valid; r_data = rsp_rdata; r_ok = rsp_sc_ok; r_mis = rsp_misaligned;
    req_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic snoop_only(input logic [31:0] saddr);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_waddr = saddr[31:2];
    @(posedge clk); #1;
    snoop_valid = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [31:0] addr, input logic [31:0] exp);
    xact(LD, addr, '0, 1'b0, '0);
    chk(req, r_data, exp);
  endtask

  task automatic t_reset_state();
    @(posedge clk); #1;
    chk("R11 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11 rsp_sc_ok in reset", {31'd0, rsp_sc_ok}, 32'd0);
  endtask

  task automatic t_init();
    xact(ST, A, 32'h1111_1111, 1'b0, '0);
    chk("R11 store response valid", {31'd0, r_valid}, 32'd1);
    @(posedge clk); #1;
    chk("R11 idle no response", {31'd0, rsp_valid}, 32'd0);
    xact(ST, B, 32'h2222_2222, 1'b0, '0);
    expect_word("R11 plain load", A, 32'h1111_1111);
  endtask

  task automatic t_link_pass();
    xact(LL, A, '0, 1'b0, '0);
    chk("R1 linked load data", r_data, 32'h1111_1111);
    xact(SC, A, 32'hAAAA_0001, 1'b0, '0);
    chk("R2 cond store ok", {31'd0, r_ok}, 32'd1);
    expect_word("R2 cond store wrote", A, 32'hAAAA_0001);
  endtask

  task automatic t_second_cond();
    xact(SC, A, 32'hBBBB_0002, 1'b0, '0);
    chk("R5 second cond fails", {31'd0, r_ok}, 32'd0);
    expect_word("R5 second cond no write", A, 32'hAAAA_0001);
  endtask

  task automatic t_snoop_between();
    xact(LL, A, '0, 1'b0, '0);
    snoop_only(A);
    xact(SC, A, 32'hCCCC_0003, 1'b0, '0);
    chk("R3 cond after snoop fails", {31'd0, r_ok}, 32'd0);
    expect_word("R3 memory unchanged", A, 32'hAAAA_0001);
  endtask

  task automatic t_store_breaks();
    xact(LL, A, '0, 1'b0, '0);
    xact(ST, A, 32'h1234_5678, 1'b0, '0);
    xact(SC, A, 32'hDDDD_0004, 1'b0, '0);
    chk("R4 cond after store fails", {31'd0, r_ok}, 32'd0);
    expect_word("R4 store value kept", A, 32'h1234_5678);
  endtask

  task automatic t_wrong_addr();
    xact(LL, A, '0, 1'b0, '0);
    xact(SC, B, 32'hEEEE_0005, 1'b0, '0);
    chk("R6 cond other word fails", {31'd0, r_ok}, 32'd0);
    expect_word("R6 other word unchanged", B, 32'h2222_2222);
  endtask

  task automatic t_same_cycle();
    xact(LL, A, '0, 1'b0, '0);
    xact(SC, A, 32'hFFFF_0006, 1'b1, A);
    chk("R7 cond with same-cycle snoop fails", {31'd0, r_ok}, 32'd0);
    expect_word("R7 memory unchanged", A, 32'h1234_5678);
  endtask

  task automatic t_other_snoop();
    xact(LL, A, '0, 1'b0, '0);
    snoop_only(C);
    xact(SC, A, 32'h5555_0007, 1'b1, B);
    chk("R8 unrelated snoops keep reservation", {31'd0, r_ok}, 32'd1);
    expect_word("R8 cond wrote", A, 32'h5555_0007);
  endtask

  task automatic t_misaligned();
    xact(LL, A, '0, 1'b0, '0);
    xact(ST, A + 32'd2, 32'h0000_0009, 1'b0, '0);
    chk("R9 misaligned flag", {31'd0, r_mis}, 32'd1);
    xact(SC, A + 32'd1, 32'h0000_000A, 1'b0, '0);
    chk("R9 misaligned cond not ok", {30'd0, r_mis, r_ok}, 32'd2);
    xact(SC, A, 32'h6666_0008, 1'b0, '0);
    chk("R9 reservation survives misaligned", {31'd0, r_ok}, 32'd1);
    expect_word("R9 no misaligned write", A, 32'h6666_0008);
  endtask

  task automatic t_link_snoop();
    xact(LL, A, '0, 1'b1, A);
    chk("R12 linked load data", r_data, 32'h6666_0008);
    xact(SC, A, 32'h7777_0009, 1'b0, '0);
    chk("R12 no reservation opened", {31'd0, r_ok}, 32'd0);
    expect_word("R12 memory unchanged", A, 32'h6666_0008);
  endtask

  task automatic t_reset_clears();
    xact(LL, A, '0, 1'b0, '0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    xact(SC, A, 32'h8888_000A, 1'b0, '0);
    chk("R10 cond after reset fails", {31'd0, r_ok}, 32'd0);
    expect_word("R10 memory unchanged", A, 32'h6666_0008);
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    @(negedge clk); rst = 1'b0;
    t_init();
    t_link_pass();
    t_second_cond();
    t_snoop_between();
    t_store_breaks();
    t_wrong_addr();
    t_same_cycle();
    t_other_snoop();
    t_misaligned();
    t_link_snoop();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule